// File: doc/BRIEF.md
# Configuration Access Port Bridge

This block sits on the host side of an I/O bus. It turns processor port reads and writes into configuration-space transactions for a downstream device model. A 32-bit selector register, reached by dword accesses at one port, holds an enable flag and a bus number. It also holds a device/function number and a register index that can reach a 4 KB space per function. A 4-byte data window that follows it forwards each byte, word or dword access as one configuration read or write, with byte enables that match the access.

Accesses to the window are forwarded only while the enable flag is set and the access is naturally aligned. Every other access completes locally: reads return all ones and writes are dropped. The I/O response is withheld until the configuration side acknowledges, so at most one configuration transaction is in flight. The parameter `EXT_REG` chooses between the 4 KB layout and the classic 256-byte layout; in the classic layout the upper index bits are forced to zero.

Top module: `cfg_port_bridge`

## Requirements
- R1: Synchronous reset clears the selector register, so a dword read of the selector port returns 0 and a window access is not forwarded.
- R2: A dword write to the selector port (default 16'h0CF8) stores all 32 bits, and a later dword read of that port returns them unchanged.
- R3: A forwarded access carries the bus from selector bits 23:16 and the device/function from bits 15:8. Its 10-bit dword index is {selector bits 27:24, selector bits 7:2} when EXT_REG=1.
- R4: The window occupies ports DATA_PORT..DATA_PORT+3 (default 16'h0CFC), with lane offset k = port bits 1:0. Size encoding: 0 = byte, 1 = word, 2 = dword. Byte enables are 4'b0001<<k for a byte, 4'b0011<<k for a word (k = 0 or 2) and 4'b1111 for a dword (k = 0).
- R5: Write data bits start at bit 8*k on the configuration side, and lanes whose enable is clear are driven as zero. Read data is returned shifted down by 8*k, with the bits above the access size set to zero.
- R6: While selector bit 31 is clear, window accesses make no configuration request. Window reads return 32'hFFFFFFFF and window writes leave the target unchanged.
- R7: A misaligned window access (a word at an odd offset, or a dword at a non-zero offset), a selector-port access that is not a dword, or an access to any other port is not forwarded. Such a read returns 32'hFFFFFFFF, and such a write changes neither the selector nor any target.
- R8: cfg_req stays high with stable command fields until cfg_ack is sampled, and it is never high at the same time as io_ack. io_ack is a single-cycle pulse, and a forwarded access is acknowledged 2+d cycles after acceptance, where d is the device's wait in cycles.
- R9: A local (non-forwarded) access is acknowledged one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | I/O request, held until io_ack |
| io_we | input | 1 | 1 = port write, 0 = port read |
| io_port | input | 16 | I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword |
| io_wdata | input | 32 | Write data, right-aligned |
| io_ack | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Read data, valid with io_ack |
| cfg_req | output | 1 | Configuration request, held until cfg_ack |
| cfg_we | output | 1 | 1 = configuration write |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function |
| cfg_reg | output | 10 | Dword register index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_ack | input | 1 | Configuration completion |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ack |

## Verification
The bench aims at byte and word accesses at each window offset. A wrong lane shift or mask would show up as corrupted neighbouring bytes in a later dword read, or as stray upper bits in the returned value. It uses a register index above 255, which a design that drops selector bits 27:24 would send to the wrong dword. It also clears the enable flag and issues misaligned and non-dword selector accesses; a design that forwards these, or lets them overwrite the selector, would change the request count or the read-back value. A device model with a wait of several cycles exposes any early release of the request or a doubled io_ack.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int IDX_W  = 10;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } io_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CFG  = 2'd1,
        ST_RESP = 2'd2
    } bridge_state_e;

    typedef struct packed {
        logic              we;
        logic [7:0]        bus;
        logic [7:0]        devfn;
        logic [IDX_W-1:0]  dw;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } cfg_cmd_t;

    // lanes covered by an access of the given size, starting at lane 0
    function automatic logic [LANES-1:0] lane_span(logic [1:0] size);
        case (size)
            SZ_BYTE:  return 4'b0001;
            SZ_WORD:  return 4'b0011;
            SZ_DWORD: return 4'b1111;
            default:  return 4'b0000;
        endcase
    endfunction

    // natural alignment of an access inside the window
    function automatic logic lane_fits(logic [1:0] size, logic [OFF_W-1:0] off);
        case (size)
            SZ_BYTE:  return 1'b1;
            SZ_WORD:  return ~off[0];
            SZ_DWORD: return (off == '0);
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_sel_reg.sv
module cfg_sel_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wr_data;
    end

    // R1: reset leaves the selector cleared
    assert_sel_clear_R1: assert property (@(posedge clk) rst |=> (q == '0));

endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
    import cfgbr_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              legal,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_out
);

    logic [LANES-1:0]  span;
    logic [DATA_W-1:0] span_bits;
    logic [DATA_W-1:0] wr_shift;
    logic [DATA_W-1:0] rd_shift;

    assign span  = lane_span(size);
    assign legal = lane_fits(size, off);
    assign be    = legal ? (span << off) : '0;

    assign wr_shift = (wdata_in & span_bits) << {off, 3'b000};
    assign rd_shift = rdata_in >> {off, 3'b000};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign span_bits[8*g +: 8] = {8{span[g]}};
        assign wdata_out[8*g +: 8] = be[g] ? wr_shift[8*g +: 8] : 8'h00;
        assign rdata_out[8*g +: 8] = span[g] ? rd_shift[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgbr_pkg::*;
#(
    parameter int               PORT_W    = 16,
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [PORT_W-1:0] DATA_PORT = 16'h0CFC,
    parameter bit               EXT_REG   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_req,
    input  logic              io_we,
    input  logic [PORT_W-1:0] io_port,
    input  logic [1:0]        io_size,
    input  logic [31:0]       io_wdata,
    output logic              io_ack,
    output logic [31:0]       io_rdata,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [7:0]        cfg_bus,
    output logic [7:0]        cfg_devfn,
    output logic [9:0]        cfg_reg,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_ack,
    input  logic [31:0]       cfg_rdata
);

    bridge_state_e     state;
    cfg_cmd_t          cmd_q;
    logic [31:0]       rdata_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        size_q;
    logic [31:0]       sel_q;
    logic [3:0]        idx_hi;

    logic              accept;
    logic              sel_hit;
    logic              win_hit;
    logic              forward;
    logic              sel_wr;

    logic [1:0]        lu_size;
    logic [OFF_W-1:0]  lu_off;
    logic              lu_legal;
    logic [LANES-1:0]  lu_be;
    logic [DATA_W-1:0] lu_wdata;
    logic [DATA_W-1:0] lu_rdata;

    // choose the index layout
    if (EXT_REG) begin : g_ext_idx
        assign idx_hi = sel_q[27:24];
    end else begin : g_classic_idx
        assign idx_hi = 4'h0;
    end

    assign accept  = (state == ST_IDLE) && io_req;
    assign sel_hit = (io_port == ADDR_PORT) && (io_size == SZ_DWORD);
    assign win_hit = (io_port[PORT_W-1:OFF_W] == DATA_PORT[PORT_W-1:OFF_W]);
    assign forward = win_hit && lu_legal && sel_q[31];
    assign sel_wr  = accept && sel_hit && io_we;

    assign lu_size = (state == ST_IDLE) ? io_size : size_q;
    assign lu_off  = (state == ST_IDLE) ? io_port[OFF_W-1:0] : off_q;

    cfg_sel_reg #(.WIDTH(32)) i_sel (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sel_wr),
        .wr_data (io_wdata),
        .q       (sel_q)
    );

    cfg_lane_unit i_lane (
        .size      (lu_size),
        .off       (lu_off),
        .wdata_in  (io_wdata),
        .rdata_in  (cfg_rdata),
        .legal     (lu_legal),
        .be        (lu_be),
        .wdata_out (lu_wdata),
        .rdata_out (lu_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cmd_q   <= '0;
            rdata_q <= '0;
            off_q   <= '0;
            size_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (io_req) begin
                        if (forward) begin
                            cmd_q.we    <= io_we;
                            cmd_q.bus   <= sel_q[23:16];
                            cmd_q.devfn <= sel_q[15:8];
                            cmd_q.dw    <= {idx_hi, sel_q[7:2]};
                            cmd_q.be    <= lu_be;
                            cmd_q.wdata <= lu_wdata;
                            off_q       <= io_port[OFF_W-1:0];
                            size_q      <= io_size;
                            state       <= ST_CFG;
                        end else begin
                            rdata_q <= (sel_hit && !io_we) ? sel_q : '1;
                            state   <= ST_RESP;
                        end
                    end
                end
                ST_CFG: begin
                    if (cfg_ack) begin
                        rdata_q <= cmd_q.we ? '1 : lu_rdata;
                        state   <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign io_ack    = (state == ST_RESP);
    assign io_rdata  = rdata_q;
    assign cfg_req   = (state == ST_CFG);
    assign cfg_we    = cmd_q.we;
    assign cfg_bus   = cmd_q.bus;
    assign cfg_devfn = cmd_q.devfn;
    assign cfg_reg   = cmd_q.dw;
    assign cfg_be    = cmd_q.be;
    assign cfg_wdata = cmd_q.wdata;

    // R8: the request and its fields hold until the device answers
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_ack) |=> (cfg_req &&
            $stable({cfg_we, cfg_bus, cfg_devfn, cfg_reg, cfg_be, cfg_wdata})));

    // R8: completion is a single-cycle pulse
    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        io_ack |=> !io_ack);

    // R8: never a pending request together with a completion
    assert_one_txn_R8: assert property (@(posedge clk) disable iff (rst)
        !(cfg_req && io_ack));

    // R6: a request is only launched while the selector enable is set
    assert_enable_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_req) |-> sel_q[31]);

    // R4: byte enables cover 1, 2 or 4 lanes
    assert_be_shape_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 ||
                     $countones(cfg_be) == 4));

endmodule

// File: tb/test_cfg_port_bridge.sv
`timescale 1ns/1ps
module test_cfg_port_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_req, io_we;
    logic [15:0] io_port;
    logic [1:0]  io_size;
    logic [31:0] io_wdata;
    logic        io_ack;
    logic [31:0] io_rdata;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_bus, cfg_devfn;
    logic [9:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack;
    logic [31:0] cfg_rdata;

    always #2 clk = ~clk;

    cfg_port_bridge i_cfg_port_bridge (
        .clk(clk), .rst(rst),
        .io_req(io_req), .io_we(io_we), .io_port(io_port), .io_size(io_size),
        .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
        .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
    );

    int checks = 0;
    int errors = 0;
    int fwd_cnt = 0;
    int dly = 0;
    int dcnt = 0;
    bit busy = 0;
    bit done = 0;

    logic [31:0] mem [int];
    logic        g_we;
    logic [7:0]  g_bus, g_devfn;
    logic [9:0]  g_reg;
    logic [3:0]  g_be;
    logic [31:0] g_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_sel(input logic [7:0] bus, input logic [7:0] devfn,
                                            input logic [11:0] rg);
        return 32'h8000_0000 | ({28'h0, rg[11:8]} << 24) | ({24'h0, bus} << 16) |
               ({24'h0, devfn} << 8) | {24'h0, rg[7:2], 2'b00};
    endfunction

    // device model: answers after dly waiting cycles, holds a sparse register file
    initial begin
        cfg_ack = 1'b0;
        cfg_rdata = '0;
        forever begin
            @(negedge clk);
            if (cfg_ack) begin
                cfg_ack = 1'b0;
            end else if (cfg_req) begin
                dcnt++;
                if (dcnt > dly) begin
                    int key;
                    logic [31:0] w;
                    dcnt = 0;
                    key = int'({cfg_bus, cfg_devfn, cfg_reg});
                    g_we = cfg_we; g_bus = cfg_bus; g_devfn = cfg_devfn;
                    g_reg = cfg_reg; g_be = cfg_be; g_wdata = cfg_wdata;
                    fwd_cnt++;
                    w = mem.exists(key) ? mem[key] : 32'h0;
                    if (cfg_we) begin
                        for (int b = 0; b < 4; b++)
                            if (cfg_be[b]) w[8*b +: 8] = cfg_wdata[8*b +: 8];
                        mem[key] = w;
                        cfg_rdata = 32'h0;
                    end else begin
                        cfg_rdata = w;
                    end
                    cfg_ack = 1'b1;
                end
            end
        end
    end

    // per-cycle protocol model, sampled 1 ns after each rising edge
    logic        p_req = 1'b0, p_ack = 1'b0;
    logic [62:0] p_fields = '0;
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            checks++;
            if ((cfg_req || io_ack) && !busy) begin
                errors++;
                $display("FAIL R8 activity without request actual %b expected 0", cfg_req | io_ack);
            end
            if (io_ack && p_ack) begin
                errors++;
                $display("FAIL R8 io_ack wider than one cycle actual 1 expected 0");
            end
            if (cfg_req && io_ack) begin
                errors++;
                $display("FAIL R8 cfg_req with io_ack actual 1 expected 0");
            end
            if (p_req && !cfg_ack &&
                (!cfg_req || {cfg_we, cfg_bus, cfg_devfn, cfg_reg, cfg_be, cfg_wdata} != p_fields)) begin
                errors++;
                $display("FAIL R8 request not held actual %b expected 1", cfg_req);
            end
        end
        p_req = cfg_req;
        p_ack = io_ack;
        p_fields = {cfg_we, cfg_bus, cfg_devfn, cfg_reg, cfg_be, cfg_wdata};
    end

    task automatic xfer(input logic we, input logic [15:0] port, input logic [1:0] size,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
        bit got = 0;
        @(negedge clk);
        io_we = we; io_port = port; io_size = size; io_wdata = wd;
        io_req = 1'b1; busy = 1'b1; lat = 0; rd = 'x;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            lat++;
            if (io_ack) begin
                rd = io_rdata;
                got = 1;
                break;
            end
        end
        io_req = 1'b0;
        if (!got) begin
            errors++;
            $display("FAIL R8 no io_ack actual 0 expected 1");
        end
        @(negedge clk);
        busy = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, s1, s2;
        int lat, n0;
        rst = 1'b1; io_req = 0; io_we = 0; io_port = '0; io_size = '0; io_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        xfer(0, 16'h0CF8, 2, 0, rd, lat); chk("R1 selector after reset", rd, 32'h0);
        chk("R9 local latency", lat, 1);
        n0 = fwd_cnt;
        xfer(0, 16'h0CFC, 2, 0, rd, lat); chk("R1 window read after reset", rd, 32'hFFFFFFFF);
        chk("R1 no forward after reset", fwd_cnt, n0);

        // R2: verbatim read-back
        xfer(1, 16'h0CF8, 2, 32'h8A123456, rd, lat);
        xfer(0, 16'h0CF8, 2, 0, rd, lat); chk("R2 selector read-back", rd, 32'h8A123456);

        // R3 R4 R5: dword write
        s1 = mk_sel(8'h03, 8'h21, 12'h010);
        xfer(1, 16'h0CF8, 2, s1, rd, lat);
        xfer(1, 16'h0CFC, 2, 32'hDEADBEEF, rd, lat);
        chk("R3 bus", g_bus, 8'h03); chk("R3 devfn", g_devfn, 8'h21);
        chk("R3 index", g_reg, 10'h004); chk("R4 dword be", g_be, 4'hF);
        chk("R5 dword wdata", g_wdata, 32'hDEADBEEF); chk("R8 write flag", g_we, 1'b1);
        chk("R8 forward latency d=0", lat, 2);

        // R4 R5: byte write at lane 2 with junk in upper input bits
        xfer(1, 16'h0CFE, 0, 32'hFFFFFF5A, rd, lat);
        chk("R4 byte be lane2", g_be, 4'h4); chk("R5 byte lane placement", g_wdata, 32'h005A0000);
        xfer(0, 16'h0CFC, 2, 0, rd, lat); chk("R5 dword read after byte write", rd, 32'hDE5ABEEF);
        xfer(0, 16'h0CFE, 1, 0, rd, lat); chk("R5 word read lane2", rd, 32'h0000DE5A);
        chk("R4 word be upper", g_be, 4'hC);
        xfer(0, 16'h0CFD, 0, 0, rd, lat); chk("R5 byte read lane1", rd, 32'h000000BE);
        chk("R4 byte be lane1", g_be, 4'h2);
        xfer(1, 16'h0CFC, 1, 32'h0000A5C3, rd, lat);
        chk("R4 word be lower", g_be, 4'h3); chk("R5 word lane placement", g_wdata, 32'h0000A5C3);
        xfer(0, 16'h0CFC, 2, 0, rd, lat); chk("R5 word write merge", rd, 32'hDE5AA5C3);

        // R3 R8: extended index and a slow device
        dly = 3;
        s2 = mk_sel(8'h80, 8'h07, 12'h9A4);
        xfer(1, 16'h0CF8, 2, s2, rd, lat);
        xfer(1, 16'h0CFC, 2, 32'h12345678, rd, lat);
        chk("R3 extended index", g_reg, 10'h269); chk("R3 extended bus", g_bus, 8'h80);
        chk("R8 forward latency d=3", lat, 5);
        xfer(0, 16'h0CFC, 2, 0, rd, lat); chk("R5 extended read-back", rd, 32'h12345678);
        dly = 0;

        // R7: misaligned, non-dword selector and foreign ports
        n0 = fwd_cnt;
        xfer(0, 16'h0CFD, 1, 0, rd, lat); chk("R7 odd word read", rd, 32'hFFFFFFFF);
        chk("R9 local latency misaligned", lat, 1);
        xfer(1, 16'h0CFE, 2, 32'h0BADF00D, rd, lat);
        chk("R7 no forward misaligned", fwd_cnt, n0);
        xfer(1, 16'h0CF8, 0, 32'h00000011, rd, lat);
        xfer(0, 16'h0CF8, 2, 0, rd, lat); chk("R7 byte selector write ignored", rd, s2);
        xfer(0, 16'h0CF8, 1, 0, rd, lat); chk("R7 word selector read", rd, 32'hFFFFFFFF);
        xfer(0, 16'h0080, 2, 0, rd, lat); chk("R7 foreign port read", rd, 32'hFFFFFFFF);
        xfer(0, 16'h0CFC, 2, 0, rd, lat); chk("R7 target unchanged", rd, 32'h12345678);

        // R6: enable cleared
        xfer(1, 16'h0CF8, 2, s2 & 32'h7FFFFFFF, rd, lat);
        n0 = fwd_cnt;
        xfer(1, 16'h0CFC, 2, 32'hAAAAAAAA, rd, lat);
        xfer(0, 16'h0CFC, 2, 0, rd, lat); chk("R6 disabled read", rd, 32'hFFFFFFFF);
        chk("R6 no forward when disabled", fwd_cnt, n0);
        xfer(1, 16'h0CF8, 2, s2, rd, lat);
        xfer(0, 16'h0CFC, 2, 0, rd, lat); chk("R6 disabled write dropped", rd, 32'h12345678);

        // R1: reset again clears a live selector
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        xfer(0, 16'h0CF8, 2, 0, rd, lat); chk("R1 selector after second reset", rd, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule